// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

This block is the priority core of a processor-side interrupt controller. It tracks 256 interrupt vectors in three bitmaps: requests waiting for service, vectors currently being serviced, and the trigger type last recorded for each vector. Sources post a vector together with its trigger type. The block compares the best waiting vector against the processor's current priority and raises an interrupt line when that vector may preempt. It answers acknowledge cycles with a vector number, and it retires the highest in-service vector when an end-of-interrupt strobe arrives.

Priority works in classes of sixteen vectors, taken from the upper nibble of the vector number. A higher number always wins. Software sets a task priority class and a 9-bit spurious register. Bit 8 of the spurious register enables the whole block. Its low byte is the vector returned when an acknowledge finds nothing it may hand out. Each bitmap can be read as eight 32-bit words through a combinational read port. The same port also returns the two control registers.

Top module: `vpa_arbiter`

## Requirements
- R1: When `set_valid` is high at a clock edge, the pending bit of `set_vec` is set. The trigger bit of that vector becomes `set_level` (1 = level, 0 = edge).
- R2: `irq` stays low while bit 8 of the spurious register is 0.
- R3: When enabled, `irq` is high exactly when a vector is pending and either the processor priority is 0 or the class (bits 7:4) of the highest pending vector is strictly greater than the class of the processor priority.
- R4: `proc_prio` equals the task priority when no vector is in service or when the task priority class is at least the class of the highest in-service vector. Otherwise it equals that in-service vector with bits 3:0 cleared.
- R5: An acknowledge returns the spurious low byte and changes no bitmap in any of these cases: the block is disabled, nothing is pending, or the task priority is nonzero and the highest pending vector is less than or equal to it.
- R6: Any other acknowledge clears the pending bit of the highest pending vector, sets its in-service bit and returns it. `ack_valid` is high in the cycle after each `ack_req`, with the answer on `ack_vec`.
- R7: `eoi` clears the highest set in-service bit. With no bit in service it has no effect.
- R8: `tpr_wr` loads the task priority with `tpr_class` in bits 7:4 and zeros in bits 3:0. `svr_wr` loads all 9 bits of the spurious register.
- R9: Reset clears all three bitmaps, sets the task priority to 0 and the spurious register to 0x0FF. `init_req` clears all three bitmaps, overrides every other bitmap update in that cycle, and leaves both registers alone.
- R10: `rd_data` selects by `rd_sel`: 0 returns pending, 1 in-service, 2 trigger, 3 control. Word `w` of a bitmap holds vector 32*w+j in bit j. The control word holds the task priority in bits 7:0, the spurious register in bits 16:8, and zeros above.
- R11: Updates in one cycle are ordered as follows. An acknowledge and an end-of-interrupt both act on the state before the edge. A set in the same cycle is applied after the acknowledge's clear, so a set of the acknowledged vector leaves it pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req | input | 1 | Clears the three bitmaps |
| set_valid | input | 1 | Post a vector request |
| set_vec | input | 8 | Vector being posted |
| set_level | input | 1 | 1 = level trigger, 0 = edge |
| ack_req | input | 1 | Acknowledge cycle request |
| ack_valid | output | 1 | Acknowledge answer valid |
| ack_vec | output | 8 | Acknowledged or spurious vector |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_wr | input | 1 | Task priority write |
| tpr_class | input | 4 | New task priority class |
| svr_wr | input | 1 | Spurious register write |
| svr_data | input | 9 | New spurious register value |
| irq | output | 1 | Interrupt request to processor |
| proc_prio | output | 8 | Current processor priority |
| rd_sel | input | 2 | Read source select |
| rd_word | input | 3 | Word index within bitmap |
| rd_data | output | 32 | Read data |

## Verification
The bench builds the block with its default parameters: 256 vectors read through 32-bit words, giving eight words per bitmap. With these values the bench can reach the class edges at 0x0F/0x10 and 0x5F/0x60, the top vector 0xFF, vector 0x00, and the word boundary between 0x1F and 0x20. Directed sequences drive the nesting of in-service classes, task-priority blocking, and the same-cycle combinations of set, acknowledge and end-of-interrupt. A long pseudo-random phase then mixes all the inputs. Throughout, the bench compares every output and every readable word against a behavioural model.

// File: rtl/vpa_pkg.sv
package vpa_pkg;

    localparam int VEC_W     = 8;
    localparam int NUM_VEC   = 1 << VEC_W;
    localparam int CLASS_LSB = 4;
    localparam int CLASS_W   = VEC_W - CLASS_LSB;
    localparam int SVR_W     = VEC_W + 1;

    typedef logic [VEC_W-1:0]   vec_t;
    typedef logic [NUM_VEC-1:0] map_t;
    typedef logic [CLASS_W-1:0] cls_t;

    typedef struct packed {
        logic found;
        vec_t idx;
    } hit_t;

    typedef struct packed {
        logic take;
        vec_t vec;
    } ack_dec_t;

    typedef enum logic [1:0] {
        RD_PEND  = 2'd0,
        RD_INSVC = 2'd1,
        RD_TRIG  = 2'd2,
        RD_CTRL  = 2'd3
    } rd_sel_e;

    function automatic cls_t class_of(input vec_t v);
        return v[VEC_W-1:CLASS_LSB];
    endfunction

    function automatic map_t onehot_of(input logic en, input vec_t v);
        map_t m;
        m    = '0;
        m[v] = en;
        return m;
    endfunction

endpackage

// File: rtl/vpa_msb_finder.sv
module vpa_msb_finder #(
    parameter int N     = 256,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     bits,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (bits[i]) idx = IDX_W'(i);
        end
        found = |bits;
    end
endmodule

// File: rtl/vpa_bitmaps.sv
module vpa_bitmaps
    import vpa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic init_req,
    input  logic set_en,
    input  vec_t set_vec,
    input  logic set_level,
    input  logic take_en,
    input  vec_t take_vec,
    input  logic retire_en,
    input  vec_t retire_vec,
    output map_t irr,
    output map_t isr,
    output map_t tmr
);
    map_t set_mask, take_mask, retire_mask;

    always_comb begin
        set_mask    = onehot_of(set_en, set_vec);
        take_mask   = onehot_of(take_en, take_vec);
        retire_mask = onehot_of(retire_en, retire_vec);
    end

    always_ff @(posedge clk) begin
        if (rst || init_req) begin
            irr <= '0;
            isr <= '0;
            tmr <= '0;
        end else begin
            irr <= (irr & ~take_mask) | set_mask;
            isr <= (isr & ~retire_mask) | take_mask;
            if (set_en) tmr[set_vec] <= set_level;
        end
    end
endmodule

// File: rtl/vpa_resolver.sv
module vpa_resolver
    import vpa_pkg::*;
(
    input  hit_t           pend_hi,
    input  hit_t           svc_hi,
    input  vec_t           tpr,
    input  logic [SVR_W-1:0] svr,
    output vec_t           ppr,
    output logic           irq,
    output ack_dec_t       dec
);
    logic enabled;
    logic tpr_blocks;

    always_comb begin
        enabled = svr[SVR_W-1];

        if (!svc_hi.found || class_of(tpr) >= class_of(svc_hi.idx))
            ppr = tpr;
        else
            ppr = {class_of(svc_hi.idx), {CLASS_LSB{1'b0}}};

        irq = enabled && pend_hi.found &&
              ((ppr == '0) || (class_of(pend_hi.idx) > class_of(ppr)));

        tpr_blocks = (tpr != '0) && (pend_hi.idx <= tpr);

        if (!enabled || !pend_hi.found || tpr_blocks) begin
            dec.take = 1'b0;
            dec.vec  = svr[VEC_W-1:0];
        end else begin
            dec.take = 1'b1;
            dec.vec  = pend_hi.idx;
        end
    end
endmodule

// File: rtl/vpa_readback.sv
module vpa_readback
    import vpa_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int NUM_WORDS = NUM_VEC / WORD_W,
    localparam int WSEL_W    = $clog2(NUM_WORDS)
) (
    input  map_t              irr,
    input  map_t              isr,
    input  map_t              tmr,
    input  logic [WORD_W-1:0] ctrl_word,
    input  rd_sel_e           sel,
    input  logic [WSEL_W-1:0] word,
    output logic [WORD_W-1:0] data
);
    logic [WORD_W-1:0] irr_w [NUM_WORDS];
    logic [WORD_W-1:0] isr_w [NUM_WORDS];
    logic [WORD_W-1:0] tmr_w [NUM_WORDS];

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        assign irr_w[g] = irr[g*WORD_W +: WORD_W];
        assign isr_w[g] = isr[g*WORD_W +: WORD_W];
        assign tmr_w[g] = tmr[g*WORD_W +: WORD_W];
    end

    always_comb begin
        unique case (sel)
            RD_PEND:  data = irr_w[word];
            RD_INSVC: data = isr_w[word];
            RD_TRIG:  data = tmr_w[word];
            default:  data = ctrl_word;
        endcase
    end
endmodule

// File: rtl/vpa_arbiter.sv
module vpa_arbiter
    import vpa_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int NUM_WORDS = NUM_VEC / WORD_W,
    localparam int WSEL_W    = $clog2(NUM_WORDS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                init_req,
    input  logic                set_valid,
    input  logic [VEC_W-1:0]    set_vec,
    input  logic                set_level,
    input  logic                ack_req,
    output logic                ack_valid,
    output logic [VEC_W-1:0]    ack_vec,
    input  logic                eoi,
    input  logic                tpr_wr,
    input  logic [CLASS_W-1:0]  tpr_class,
    input  logic                svr_wr,
    input  logic [SVR_W-1:0]    svr_data,
    output logic                irq,
    output logic [VEC_W-1:0]    proc_prio,
    input  logic [1:0]          rd_sel,
    input  logic [WSEL_W-1:0]   rd_word,
    output logic [WORD_W-1:0]   rd_data
);
    localparam int CTRL_PAD = WORD_W - SVR_W - VEC_W;

    map_t             irr_map, isr_map, tmr_map;
    hit_t             pend_hi, svc_hi;
    vec_t             tpr_q;
    logic [SVR_W-1:0] svr_q;
    ack_dec_t         dec;
    logic             take_en;
    logic [WORD_W-1:0] ctrl_word;

    vpa_msb_finder #(.N(NUM_VEC)) u_pend_find (
        .bits(irr_map), .found(pend_hi.found), .idx(pend_hi.idx)
    );

    vpa_msb_finder #(.N(NUM_VEC)) u_svc_find (
        .bits(isr_map), .found(svc_hi.found), .idx(svc_hi.idx)
    );

    vpa_resolver u_resolve (
        .pend_hi(pend_hi), .svc_hi(svc_hi), .tpr(tpr_q), .svr(svr_q),
        .ppr(proc_prio), .irq(irq), .dec(dec)
    );

    assign take_en = ack_req && dec.take;

    vpa_bitmaps u_maps (
        .clk(clk), .rst(rst), .init_req(init_req),
        .set_en(set_valid), .set_vec(set_vec), .set_level(set_level),
        .take_en(take_en), .take_vec(dec.vec),
        .retire_en(eoi && svc_hi.found), .retire_vec(svc_hi.idx),
        .irr(irr_map), .isr(isr_map), .tmr(tmr_map)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tpr_q     <= '0;
            svr_q     <= SVR_W'(9'h0FF);
            ack_valid <= 1'b0;
            ack_vec   <= '0;
        end else begin
            if (tpr_wr) tpr_q <= {tpr_class, {CLASS_LSB{1'b0}}};
            if (svr_wr) svr_q <= svr_data;
            ack_valid <= ack_req;
            if (ack_req) ack_vec <= dec.vec;
        end
    end

    assign ctrl_word = {{CTRL_PAD{1'b0}}, svr_q, tpr_q};

    vpa_readback #(.WORD_W(WORD_W)) u_read (
        .irr(irr_map), .isr(isr_map), .tmr(tmr_map), .ctrl_word(ctrl_word),
        .sel(rd_sel_e'(rd_sel)), .word(rd_word), .data(rd_data)
    );
endmodule

// File: rtl/vpa_checker.sv
module vpa_checker
    import vpa_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             init_req,
    input logic             ack_req,
    input logic             ack_valid,
    input logic             eoi,
    input logic             irq,
    input logic [VEC_W-1:0] proc_prio,
    input vec_t             tpr_q,
    input logic [SVR_W-1:0] svr_q,
    input map_t             irr_map,
    input map_t             isr_map,
    input map_t             tmr_map
);
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        !svr_q[SVR_W-1] |-> !irq); // R2

    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
        irq |-> (irr_map != '0)); // R3

    AST_PPR_AT_LEAST_TPR: assert property (@(posedge clk) disable iff (rst)
        proc_prio >= tpr_q); // R4

    AST_ACK_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        ack_req |=> ack_valid); // R6

    AST_NO_UNASKED_ACK: assert property (@(posedge clk) disable iff (rst)
        !ack_req |=> !ack_valid); // R6

    AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (rst)
        (eoi && !ack_req && !init_req && (isr_map != '0)) |=>
        ($countones(isr_map) == $past($countones(isr_map)) - 1)); // R7

    AST_INIT_EMPTIES_MAPS: assert property (@(posedge clk) disable iff (rst)
        init_req |=> (irr_map == '0 && isr_map == '0 && tmr_map == '0)); // R9
endmodule

bind vpa_arbiter vpa_checker u_vpa_checker (
    .clk(clk), .rst(rst), .init_req(init_req), .ack_req(ack_req),
    .ack_valid(ack_valid), .eoi(eoi), .irq(irq), .proc_prio(proc_prio),
    .tpr_q(tpr_q), .svr_q(svr_q), .irr_map(irr_map), .isr_map(isr_map),
    .tmr_map(tmr_map)
);

// File: tb/vpa_arbiter_tb.sv
`timescale 1ns/1ps
module vpa_arbiter_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init_req = 0, set_valid = 0, set_level = 0, ack_req = 0;
    logic        eoi = 0, tpr_wr = 0, svr_wr = 0;
    logic [7:0]  set_vec = 0;
    logic [3:0]  tpr_class = 0;
    logic [8:0]  svr_data = 0;
    logic [1:0]  rd_sel = 0;
    logic [2:0]  rd_word = 0;
    logic        ack_valid, irq;
    logic [7:0]  ack_vec, proc_prio;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;

    // behavioural model state
    logic [255:0] m_irr, m_isr, m_tmr;
    int m_tpr, m_svr;
    int e_ack_valid, e_ack_vec, e_spur;

    always #2 clk = ~clk;

    vpa_arbiter dut_i (
        .clk(clk), .rst(rst), .init_req(init_req), .set_valid(set_valid),
        .set_vec(set_vec), .set_level(set_level), .ack_req(ack_req),
        .ack_valid(ack_valid), .ack_vec(ack_vec), .eoi(eoi),
        .tpr_wr(tpr_wr), .tpr_class(tpr_class), .svr_wr(svr_wr),
        .svr_data(svr_data), .irq(irq), .proc_prio(proc_prio),
        .rd_sel(rd_sel), .rd_word(rd_word), .rd_data(rd_data)
    );

    function automatic int top_bit(input logic [255:0] m);
        for (int i = 255; i >= 0; i--) if (m[i]) return i;
        return -1;
    endfunction

    function automatic int exp_ppr();
        int ih = top_bit(m_isr);
        if (ih < 0 || (m_tpr >> 4) >= (ih >> 4)) return m_tpr;
        return ih & 'hF0;
    endfunction

    function automatic int exp_irq();
        int ph = top_bit(m_irr);
        int p  = exp_ppr();
        if (m_svr[8] == 0 || ph < 0) return 0;
        return (p == 0 || (ph >> 4) > (p >> 4)) ? 1 : 0;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic sweep();
        for (int s = 0; s < 4; s++) begin
            for (int w = 0; w < 8; w++) begin
                rd_sel = 2'(s);
                rd_word = 3'(w);
                #0.2;
                case (s)
                    0: chk("R10/R1 pending word", rd_data, m_irr[w*32 +: 32]);
                    1: chk("R10/R6 in-service word", rd_data, m_isr[w*32 +: 32]);
                    2: chk("R10/R1 trigger word", rd_data, m_tmr[w*32 +: 32]);
                    default: chk("R10/R8 control word", rd_data, (m_svr << 8) | m_tpr);
                endcase
            end
        end
    endtask

    task automatic compare();
        chk(m_svr[8] ? "R3 irq" : "R2 irq while disabled", irq, exp_irq());
        chk("R4 proc_prio", proc_prio, exp_ppr());
        chk("R6 ack_valid", ack_valid, e_ack_valid);
        if (e_ack_valid != 0)
            chk(e_spur != 0 ? "R5 spurious ack_vec" : "R6 ack_vec", ack_vec, e_ack_vec);
    endtask

    // apply currently driven inputs for one edge; update model; compare
    task automatic tick();
        int ph = top_bit(m_irr);
        int ih = top_bit(m_isr);
        int take = 0;
        logic [255:0] n_irr = m_irr, n_isr = m_isr, n_tmr = m_tmr;
        e_ack_valid = ack_req;
        e_spur = 0;
        if (ack_req) begin
            if (m_svr[8] == 0 || ph < 0 || (m_tpr != 0 && ph <= m_tpr)) begin
                e_ack_vec = m_svr & 'hFF;
                e_spur = 1;
            end else begin
                e_ack_vec = ph;
                take = 1;
            end
        end
        if (eoi && ih >= 0) n_isr[ih] = 1'b0;
        if (take != 0) begin
            n_irr[ph] = 1'b0;
            n_isr[ph] = 1'b1;
        end
        if (set_valid) begin
            n_irr[set_vec] = 1'b1;
            n_tmr[set_vec] = set_level;
        end
        if (init_req) begin
            n_irr = '0; n_isr = '0; n_tmr = '0;
        end
        if (tpr_wr) m_tpr = int'(tpr_class) << 4;
        if (svr_wr) m_svr = int'(svr_data);
        m_irr = n_irr; m_isr = n_isr; m_tmr = n_tmr;
        @(posedge clk);
        @(negedge clk);
        init_req = 0; set_valid = 0; ack_req = 0; eoi = 0; tpr_wr = 0; svr_wr = 0;
        compare();
    endtask

    task automatic post(input int v, input bit lvl);
        set_valid = 1; set_vec = 8'(v); set_level = lvl;
        tick();
    endtask

    task automatic ack();
        ack_req = 1;
        tick();
    endtask

    task automatic end_int();
        eoi = 1;
        tick();
    endtask

    task automatic write_svr(input int v);
        svr_wr = 1; svr_data = 9'(v);
        tick();
    endtask

    task automatic write_tpr(input int c);
        tpr_wr = 1; tpr_class = 4'(c);
        tick();
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        m_irr = '0; m_isr = '0; m_tmr = '0;
        m_tpr = 0; m_svr = 'h0FF;
        e_ack_valid = 0; e_ack_vec = 0; e_spur = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R9: reset state
        compare();
        sweep();

        // R2: pending but disabled -> no irq; acknowledge returns spurious
        post('h45, 0);
        ack();
        sweep();

        // enable; R3 irq; R6 acknowledge takes 0x45
        write_svr('h1F0);
        ack();
        sweep();
        // R3 same class pending does not preempt; higher class does
        post('h47, 0);
        post('h51, 1);
        ack();
        // R4 nested in-service priority; R7 retire highest first
        end_int();
        sweep();
        end_int();
        ack();
        end_int();
        // R7 eoi with nothing in service is ignored
        end_int();
        sweep();

        // R5 task priority blocks 0x60 (equal), R8 tpr load
        write_tpr(6);
        post('h60, 0);
        ack();
        sweep();
        post('h61, 1);
        ack();      // 0x61 > 0x60 taken even though irq is low
        sweep();
        end_int();
        write_tpr(0);
        ack();      // 0x60 now taken
        end_int();

        // R11 same-cycle set and acknowledge of the same vector
        post('h20, 0);
        post('h1F, 1);
        set_valid = 1; set_vec = 8'h20; set_level = 0; ack_req = 1;
        tick();
        sweep();
        // R11 eoi and acknowledge in the same cycle
        eoi = 1; ack_req = 1;
        tick();
        sweep();

        // boundary vectors 0xFF and 0x00
        post('hFF, 1);
        post('h00, 0);
        ack();
        ack();
        sweep();
        end_int();

        // R9 init clears maps, keeps registers
        write_tpr(3);
        post('h33, 1);
        init_req = 1; set_valid = 1; set_vec = 8'h77;
        tick();
        sweep();
        write_tpr(0);

        // mixed pseudo-random traffic
        for (int c = 0; c < 3000; c++) begin
            set_valid = ($urandom % 2) == 0;
            set_vec   = 8'($urandom);
            set_level = 1'($urandom);
            ack_req   = ($urandom % 10) < 3;
            eoi       = ($urandom % 10) < 2;
            tpr_wr    = ($urandom % 40) == 0;
            tpr_class = 4'($urandom);
            svr_wr    = ($urandom % 60) == 0;
            svr_data  = {($urandom % 4) != 0, 8'($urandom)};
            init_req  = ($urandom % 200) == 0;
            tick();
            if (c % 16 == 0) sweep();
        end
        sweep();

        summary();
        $finish;
    end
endmodule